// File: doc/BRIEF.md
# SDRAM Data-Bus Timing Unit

This block sits between an SDRAM command scheduler and the data-bus pins. It watches the command stream (NOP, READ, WRITE, burst stop) and works out, clock by clock, when read data will appear on the shared DQ bus, when the controller must drive write data, and when the two would collide. Read beats reach the bus a programmable CAS latency after they are issued. Write beats are driven in the same cycle they are issued.

The byte-mask input acts on the two directions with different delays. For reads it removes a beat two clocks after it is sampled. For writes it suppresses the drive in the same cycle. A WRITE takes the bus immediately, even from a read that is still in flight. A READ or WRITE issued during a burst cuts that burst short, and a burst stop ends it. The conflict output tells the scheduler that a read beat it had not masked was pushed off the bus by write data. Address generation and bank timing belong to other blocks.

Top module: `sdr_dpath_timing`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released, rd_capture_o, wr_drive_o and conflict_o are all low.
- R2: Every read beat issued at clock edge k produces a read-capture strobe in the cycle after edge k+CL. CL is the value of cas_lat_i and may be 1, 2 or 3; the code 0 behaves as 1.
- R3: When dqm_i is high at edge s, no read-capture strobe is given in the cycle after edge s+2. dqm_i low lets the beat through.
- R4: A write beat at edge e raises wr_drive_o in the following cycle if dqm_i is low at edge e. It leaves wr_drive_o low if dqm_i is high at that edge.
- R5: A READ or WRITE command at edge k starts a burst of 1, 2, 4 or 8 beats, for bl_code_i values 0, 1, 2 and 3. The beats fall on consecutive edges starting at k.
- R6: A write beat always wins the bus. A read strobe that falls due in a write-beat cycle is dropped, whatever dqm_i is. rd_capture_o and wr_drive_o are never high together.
- R7: conflict_o is high in the cycle after edge e exactly when a read beat that was not masked falls due at e and a write beat with dqm_i low is driven at e.
- R8: A burst stop (cmd_i = 3) at edge e produces no beat at e or after. Beats issued before e still complete.
- R9: A READ or WRITE issued during a burst ends that burst and starts its own burst. Read beats issued before it still reach the bus.
- R10: Command encoding on cmd_i is 0 = NOP, 1 = READ, 2 = WRITE, 3 = burst stop. A NOP continues any burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 0 NOP, 1 READ, 2 WRITE, 3 burst stop |
| bl_code_i | input | BLC_W (2) | Burst length code, sampled with READ/WRITE |
| cas_lat_i | input | CL_W (2) | CAS latency, 1..MAX_CL; held steady while reads are in flight |
| dqm_i | input | 1 | Data mask for the current clock |
| rd_capture_o | output | 1 | Read data valid on the bus this cycle |
| wr_drive_o | output | 1 | Controller drives write data this cycle |
| conflict_o | output | 1 | Unmasked read beat displaced by a write |

## Verification
The embedded properties are checked on every cycle. They cover four rules: read strobes and write drives never overlap; a conflict always coincides with a write drive; a write beat issued with the mask low drives the bus on the next clock; and a mask sampled high blocks the read strobe three samples later. A burst stop is also checked to leave no write drive behind it. The exact cycle of each read strobe under each CAS latency, the burst lengths, and truncation by an interrupting command can only be shown by the bench. So can the exact firing of the conflict flag. The bench compares every output on every cycle against its own model, across directed sequences and seeded random command streams.

// File: rtl/sdr_dpath_pkg.sv
package sdr_dpath_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_BST   = 2'd3
  } cmd_e;
endpackage

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_dpath_pkg::*;
#(
  parameter int BLC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic [BLC_W-1:0] bl_code_i,
  output logic             rd_beat_o,
  output logic             wr_beat_o
);
  localparam int CNT_W = (1 << BLC_W) - 1;

  logic [CNT_W-1:0] left_q, left_d, new_len;
  logic [CNT_W:0]   beats;
  logic             wr_q, wr_d;

  always_comb begin
    beats   = (CNT_W+1)'(1) << bl_code_i;
    new_len = CNT_W'(beats - 1'b1);
  end

  always_comb begin
    rd_beat_o = 1'b0;
    wr_beat_o = 1'b0;
    left_d    = left_q;
    wr_d      = wr_q;
    unique case (cmd_i)
      CMD_READ: begin
        rd_beat_o = 1'b1;
        left_d    = new_len;
        wr_d      = 1'b0;
      end
      CMD_WRITE: begin
        wr_beat_o = 1'b1;
        left_d    = new_len;
        wr_d      = 1'b1;
      end
      CMD_BST: left_d = '0;
      default: begin
        if (left_q != '0) begin
          rd_beat_o = ~wr_q;
          wr_beat_o = wr_q;
          left_d    = left_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      left_q <= left_d;
      wr_q   <= wr_d;
    end
  end

  // R8: after a stop, no NOP may continue a burst
  p_bst_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_BST) |=> (cmd_i != CMD_NOP) || (!rd_beat_o && !wr_beat_o));
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int MAX_CL  = 3,
  parameter int DQM_LAT = 2,
  localparam int CL_W   = $clog2(MAX_CL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_beat_i,
  input  logic [CL_W-1:0] cl_i,
  input  logic            dqm_i,
  output logic            rd_due_o
);
  logic [MAX_CL-1:0]  sr_q;
  logic [DQM_LAT-1:0] dqm_q;
  logic [CL_W-1:0]    cl_eff;

  generate
    if (MAX_CL == 1) begin : g_sr1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= rd_beat_i;
    end else begin : g_srn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[MAX_CL-2:0], rd_beat_i};
    end
    if (DQM_LAT == 1) begin : g_dq1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) dqm_q <= '0;
        else         dqm_q <= dqm_i;
    end else begin : g_dqn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) dqm_q <= '0;
        else         dqm_q <= {dqm_q[DQM_LAT-2:0], dqm_i};
    end
  endgenerate

  always_comb begin
    cl_eff = cl_i;
    if (cl_i == '0) cl_eff = CL_W'(1);
    else if (int'(cl_i) > MAX_CL) cl_eff = CL_W'(MAX_CL);
  end

  // tap at CAS latency; read mask applied DQM_LAT clocks after sampling
  assign rd_due_o = sr_q[cl_eff - 1'b1] & ~dqm_q[DQM_LAT-1];
endmodule

// File: rtl/sdr_bus_arb.sv
module sdr_bus_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_due_i,
  input  logic wr_beat_i,
  input  logic dqm_i,
  output logic rd_capture_o,
  output logic wr_drive_o,
  output logic conflict_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_capture_o <= 1'b0;
      wr_drive_o   <= 1'b0;
      conflict_o   <= 1'b0;
    end else begin
      rd_capture_o <= rd_due_i & ~wr_beat_i;   // write owns the bus
      wr_drive_o   <= wr_beat_i & ~dqm_i;      // zero-latency write mask
      conflict_o   <= rd_due_i & wr_beat_i & ~dqm_i;
    end
  end

  p_bus_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_capture_o && wr_drive_o));

  p_conflict_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> wr_drive_o);
endmodule

// File: rtl/sdr_dpath_timing.sv
module sdr_dpath_timing
  import sdr_dpath_pkg::*;
#(
  parameter int MAX_CL = 3,
  parameter int BLC_W  = 2,
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cmd_i,
  input  logic [BLC_W-1:0] bl_code_i,
  input  logic [CL_W-1:0]  cas_lat_i,
  input  logic             dqm_i,
  output logic             rd_capture_o,
  output logic             wr_drive_o,
  output logic             conflict_o
);
  localparam int DQM_RD_LAT = 2;

  cmd_e cmd;
  logic rd_beat, wr_beat, rd_due;

  assign cmd = cmd_e'(cmd_i);

  sdr_burst_seq #(.BLC_W(BLC_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .bl_code_i (bl_code_i),
    .rd_beat_o (rd_beat),
    .wr_beat_o (wr_beat)
  );

  sdr_rd_pipe #(.MAX_CL(MAX_CL), .DQM_LAT(DQM_RD_LAT)) i_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_beat_i (rd_beat),
    .cl_i      (cas_lat_i),
    .dqm_i     (dqm_i),
    .rd_due_o  (rd_due)
  );

  sdr_bus_arb i_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_due_i     (rd_due),
    .wr_beat_i    (wr_beat),
    .dqm_i        (dqm_i),
    .rd_capture_o (rd_capture_o),
    .wr_drive_o   (wr_drive_o),
    .conflict_o   (conflict_o)
  );

  p_wr_zero_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd2 && !dqm_i) |=> wr_drive_o);

  p_bst_no_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd3) |=> (!wr_drive_o && !conflict_o));

  p_dqm_rd_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_i |-> ##3 !rd_capture_o);
endmodule

// File: tb/test_sdr_dpath_timing.sv
`timescale 1ns/1ps
module test_sdr_dpath_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmd = 2'd0, bl = 2'd0, cl = 2'd1;
  logic       dqm = 1'b0;
  logic       rd_cap, wr_drv, confl;

  int n_tests = 0, n_fail = 0, edge_n = 0, left_m = 0;
  bit wrmode_m = 0, done = 0;
  bit due_m[16];
  bit dqm_h[16];
  bit exp_rd, exp_wr, exp_cf;
  string tag = "R1";

  always #2.5 clk = ~clk;

  sdr_dpath_timing i_sdr_dpath_timing (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .bl_code_i(bl),
    .cas_lat_i(cl), .dqm_i(dqm),
    .rd_capture_o(rd_cap), .wr_drive_o(wr_drv), .conflict_o(confl)
  );

  function automatic int cl_of(logic [1:0] c);
    return (c == 2'd0) ? 1 : int'(c);
  endfunction

  task automatic chk(string what, bit act, bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s @edge %0d: actual %0b expected %0b", tag, what, edge_n, act, exp);
    end
  endtask

  // model of one clock edge, from the requirements
  task automatic model_edge();
    bit rb = 0, wb = 0, rdv;
    int len = 1 << bl;
    case (cmd)
      2'd1: begin rb = 1; left_m = len - 1; wrmode_m = 0; end
      2'd2: begin wb = 1; left_m = len - 1; wrmode_m = 1; end
      2'd3: left_m = 0;
      default: if (left_m > 0) begin rb = !wrmode_m; wb = wrmode_m; left_m--; end
    endcase
    if (rb) due_m[(edge_n + cl_of(cl)) % 16] = 1;
    dqm_h[edge_n % 16] = dqm;
    rdv = due_m[edge_n % 16] && !dqm_h[(edge_n + 14) % 16];
    due_m[edge_n % 16] = 0;
    exp_rd = rdv && !wb;
    exp_wr = wb && !dqm;
    exp_cf = rdv && wb && !dqm;
  endtask

  task automatic step(logic [1:0] c, logic [1:0] b, logic m);
    cmd = c; bl = b; dqm = m;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("rd_capture_o", rd_cap, exp_rd);
    chk("wr_drive_o", wr_drv, exp_wr);
    chk("conflict_o", confl, exp_cf);
    edge_n++;
  endtask

  task automatic flush();
    for (int i = 0; i < 12; i++) step(2'd0, 2'd0, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin due_m[i] = 0; dqm_h[i] = 0; end
    void'($urandom(32'h5eed_0c1a));
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("rd_capture_o", rd_cap, 0);
    chk("wr_drive_o", wr_drv, 0);
    chk("conflict_o", confl, 0);
    rst_n = 1'b1;
    step(2'd0, 2'd0, 1'b0);  // R1: cycle after release stays quiet

    // R2: single BL4 read at each CAS latency, including code 0
    for (int c = 0; c < 4; c++) begin
      tag = "R2"; cl = 2'(c);
      step(2'd1, 2'd2, 1'b0);
      flush();
    end
    // R3: mask one beat of a read burst
    tag = "R3"; cl = 2'd2;
    step(2'd1, 2'd2, 1'b0); step(2'd0, 2'd0, 1'b1); step(2'd0, 2'd0, 1'b0);
    flush();
    // R4: write burst with one masked beat
    tag = "R4";
    step(2'd2, 2'd2, 1'b0); step(2'd0, 2'd0, 1'b1); step(2'd0, 2'd0, 1'b0);
    flush();
    // R5: every burst length, read and write
    tag = "R5";
    for (int b = 0; b < 4; b++) begin
      step(2'd1, 2'(b), 1'b0); flush();
      step(2'd2, 2'(b), 1'b0); flush();
    end
    // R6, R7: write cuts an unmasked read at CL3
    tag = "R7"; cl = 2'd3;
    step(2'd1, 2'd3, 1'b0); step(2'd0, 2'd0, 1'b0); step(2'd0, 2'd0, 1'b0);
    step(2'd0, 2'd0, 1'b0); step(2'd2, 2'd1, 1'b0);
    flush();
    // R6: masked read ahead of the write avoids conflict
    tag = "R6";
    step(2'd1, 2'd3, 1'b0); step(2'd0, 2'd0, 1'b1); step(2'd0, 2'd0, 1'b1);
    step(2'd2, 2'd2, 1'b1); step(2'd0, 2'd0, 1'b0);
    flush();
    // R8: burst stop on write and on read
    tag = "R8"; cl = 2'd2;
    step(2'd2, 2'd3, 1'b0); step(2'd0, 2'd0, 1'b0); step(2'd3, 2'd0, 1'b0);
    flush();
    step(2'd1, 2'd3, 1'b0); step(2'd0, 2'd0, 1'b0); step(2'd3, 2'd0, 1'b0);
    flush();
    // R9: read interrupted by read, write interrupted by read
    tag = "R9";
    step(2'd1, 2'd3, 1'b0); step(2'd0, 2'd0, 1'b0); step(2'd1, 2'd0, 1'b0);
    flush();
    step(2'd2, 2'd3, 1'b0); step(2'd1, 2'd1, 1'b0);
    flush();
    // R10: NOPs continue, random mix per CAS latency
    for (int c = 0; c < 4; c++) begin
      tag = (c == 0) ? "R10" : "R2";
      cl = 2'(c);
      for (int i = 0; i < 400; i++) begin
        int r = $urandom_range(0, 9);
        logic [1:0] cc = (r < 5) ? 2'd0 : (r < 7) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
        step(cc, 2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0));
      end
      flush();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule